// File: doc/BRIEF.md
# Integer shift and rotate unit

A purely combinational shifter for a 32-bit integer execution datapath. A 6-bit function code and a selector bit choose between left shift, logical right shift, arithmetic right shift and right rotate. The shift distance comes from one of two places, depending on the function code. The immediate forms use a 5-bit field taken from the instruction. The variable forms use the low five bits of a register operand. The result appears in the same cycle the inputs are presented.

Two function codes carry both a logical right shift and a right rotate. The selector bit tells them apart: 0 picks the shift and 1 picks the rotate. This applies to the immediate form and to the variable form. A function code outside the legal set raises an illegal-function flag and forces the result to zero. Decoding of the no-operation variants of the left shift is left to the instruction decoder.

Top module: `shf_unit`

## Requirements
- R1: Function code 0x00 shifts the data operand left by the immediate amount, filling the low bits with zeros.
- R2: Function code 0x02 with selector 0 shifts right logically by the immediate amount. With selector 1 it rotates right by the immediate amount, so that bit i of the result is bit (i+n) mod 32 of the operand.
- R3: Function code 0x03 shifts right arithmetically by the immediate amount. Every vacated upper bit is a copy of operand bit 31.
- R4: Function code 0x04 shifts left by the register amount.
- R5: Function code 0x06 with selector 0 shifts right logically by the register amount. With selector 1 it rotates right by the register amount.
- R6: Function code 0x07 shifts right arithmetically by the register amount.
- R7: The variable forms use only bits 4..0 of the register shift operand and ignore the immediate field. The immediate forms ignore the register shift operand.
- R8: A rotate by a distance of 0 returns the operand unchanged, in both the immediate and the variable form.
- R9: Every function code other than 0x00, 0x02, 0x03, 0x04, 0x06 and 0x07 drives the illegal flag to 1 and the result to 0. Every legal code drives the flag to 0.
- R10: The selector bit has no effect on function codes 0x00, 0x03, 0x04 and 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fn_code | input | 6 | Function code that selects the operation |
| rot_sel | input | 1 | Selects rotate (1) or logical shift (0) on codes 0x02 and 0x06 |
| imm_amt | input | 5 | Immediate shift distance |
| amt_reg | input | 32 | Register operand that holds the variable shift distance |
| data_in | input | 32 | Operand to be shifted or rotated |
| result | output | 32 | Shifted or rotated value, or zero for an illegal code |
| bad_fn | output | 1 | High when the function code is not a legal shift code |

## Verification
The bench builds the unit with its default width of 32, which gives a 5-bit distance. A full sweep of every distance from 0 to 31 is therefore short enough to run for each of the eight legal operations, with fresh random operands each time. Within that sweep the rotate-by-zero case, the full 31-bit arithmetic fill and the wrap of bits through a rotate all occur. Every one of the 64 function codes is also driven with both selector values, which covers the illegal set in full.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int FN_W = 6;

  localparam logic [FN_W-1:0] FN_LEFT_IMM  = 6'h00;
  localparam logic [FN_W-1:0] FN_RIGHT_IMM = 6'h02;
  localparam logic [FN_W-1:0] FN_ARITH_IMM = 6'h03;
  localparam logic [FN_W-1:0] FN_LEFT_VAR  = 6'h04;
  localparam logic [FN_W-1:0] FN_RIGHT_VAR = 6'h06;
  localparam logic [FN_W-1:0] FN_ARITH_VAR = 6'h07;

  typedef struct packed {
    logic valid;
    logic left;
    logic arith;
    logic rotate;
    logic use_reg;
  } shf_ctl_t;

endpackage

// File: rtl/shf_decode.sv
module shf_decode
  import shf_pkg::*;
(
  input  logic [FN_W-1:0] fn_code,
  input  logic            rot_sel,
  output shf_ctl_t        ctl
);

  always_comb begin
    ctl = '0;
    unique case (fn_code)
      FN_LEFT_IMM:  begin ctl.valid = 1'b1; ctl.left = 1'b1; end
      FN_RIGHT_IMM: begin ctl.valid = 1'b1; ctl.rotate = rot_sel; end
      FN_ARITH_IMM: begin ctl.valid = 1'b1; ctl.arith = 1'b1; end
      FN_LEFT_VAR:  begin ctl.valid = 1'b1; ctl.left = 1'b1; ctl.use_reg = 1'b1; end
      FN_RIGHT_VAR: begin ctl.valid = 1'b1; ctl.rotate = rot_sel; ctl.use_reg = 1'b1; end
      FN_ARITH_VAR: begin ctl.valid = 1'b1; ctl.arith = 1'b1; ctl.use_reg = 1'b1; end
      default:      ctl = '0;
    endcase
  end

  // At most one mode flag may be set, and only on a legal code (R9)
  always_comb begin
    p_mode_exclusive_r9: assert ($countones({ctl.left, ctl.arith, ctl.rotate}) <= 1 &&
                                 (ctl.valid || !(ctl.left || ctl.arith || ctl.rotate || ctl.use_reg)))
      else $error("decode produced conflicting mode flags");
  end

endmodule

// File: rtl/shf_amount.sv
module shf_amount #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          use_reg,
  input  logic [AW-1:0] imm_amt,
  input  logic [W-1:0]  amt_reg,
  output logic [AW-1:0] amt
);

  always_comb begin
    if (use_reg) amt = amt_reg[AW-1:0];
    else         amt = imm_amt;
  end

endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  data,
  input  logic [AW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  input  logic          rotate,
  output logic [W-1:0]  out
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [AW:0][W-1:0] stg;
  logic [W-1:0]       data_rev;
  logic [W-1:0]       last_rev;
  logic               fill;

  // a left shift reuses the right-going network on a bit-reversed operand
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i] = data[W-1-i];
    assign last_rev[i] = stg[AW][W-1-i];
  end

  assign fill   = arith & data[W-1];
  assign stg[0] = left ? data_rev : data;

  // each stage moves by a power of two below W, so the wrap term never
  // needs a shift by the full width
  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    assign moved = (stg[k] >> S) |
                   (rotate ? (stg[k] << (W - S)) :
                    (fill  ? ~(ALL_ONES >> S) : '0));
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign out = left ? last_rev : stg[AW];

  always_comb begin
    // R8: a zero distance rotate returns the operand
    p_rot_zero_r8: assert (!(rotate && amt == '0) || out == data)
      else $error("rotate by zero altered operand");
    // R3: arithmetic right shift keeps the sign bit
    p_arith_sign_r3: assert (!arith || out[W-1] == data[W-1])
      else $error("arithmetic shift lost sign");
    // R1: a left shift by a non-zero distance clears bit 0
    p_left_lsb_r1: assert (!(left && amt != '0) || out[0] == 1'b0)
      else $error("left shift left a low bit set");
    // R2: a rotate preserves the count of ones
    p_rot_pop_r2: assert (!rotate || $countones(out) == $countones(data))
      else $error("rotate changed population");
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [FN_W-1:0] fn_code,
  input  logic            rot_sel,
  input  logic [AW-1:0]   imm_amt,
  input  logic [W-1:0]    amt_reg,
  input  logic [W-1:0]    data_in,
  output logic [W-1:0]    result,
  output logic            bad_fn
);

  shf_ctl_t      ctl;
  logic [AW-1:0] amt;
  logic [W-1:0]  core_out;

  shf_decode u_dec (
    .fn_code (fn_code),
    .rot_sel (rot_sel),
    .ctl     (ctl)
  );

  shf_amount #(.W(W), .AW(AW)) u_amt (
    .use_reg (ctl.use_reg),
    .imm_amt (imm_amt),
    .amt_reg (amt_reg),
    .amt     (amt)
  );

  shf_core #(.W(W), .AW(AW)) u_core (
    .data   (data_in),
    .amt    (amt),
    .left   (ctl.left),
    .arith  (ctl.arith),
    .rotate (ctl.rotate),
    .out    (core_out)
  );

  assign bad_fn = ~ctl.valid;
  assign result = ctl.valid ? core_out : '0;

  always_comb begin
    // R9: an illegal code never leaks a value
    p_illegal_zero_r9: assert (!bad_fn || result == '0)
      else $error("illegal code produced non-zero result");
  end

endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  fn;
    logic        sel;
    logic [4:0]  imm;
    logic [31:0] rs;
    logic [31:0] d;
    logic [31:0] exp_res;
    logic        exp_bad;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  6'h00, 1'b0, 5'd4,  32'h0000_0000, 32'h0000_00F1, 32'h0000_0F10, 1'b0}, // R1
    '{4'd2,  6'h02, 1'b0, 5'd8,  32'h0000_0000, 32'h8000_1234, 32'h0080_0012, 1'b0}, // R2 shift
    '{4'd2,  6'h02, 1'b1, 5'd8,  32'h0000_0000, 32'h1234_5678, 32'h7812_3456, 1'b0}, // R2 rotate
    '{4'd3,  6'h03, 1'b0, 5'd4,  32'h0000_0000, 32'h8000_0000, 32'hF800_0000, 1'b0}, // R3 negative
    '{4'd3,  6'h03, 1'b0, 5'd4,  32'h0000_0000, 32'h7000_0000, 32'h0700_0000, 1'b0}, // R3 positive
    '{4'd4,  6'h04, 1'b0, 5'd31, 32'hFFFF_FFE1, 32'h8000_0001, 32'h0000_0002, 1'b0}, // R4
    '{4'd7,  6'h06, 1'b0, 5'd9,  32'h0000_0020, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0}, // R7 upper bits
    '{4'd5,  6'h06, 1'b1, 5'd0,  32'h0000_0004, 32'h1234_5678, 32'h8123_4567, 1'b0}, // R5
    '{4'd6,  6'h07, 1'b0, 5'd0,  32'h0000_001F, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0}, // R6
    '{4'd8,  6'h02, 1'b1, 5'd0,  32'h0000_0007, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 1'b0}, // R8
    '{4'd9,  6'h01, 1'b0, 5'd3,  32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1}, // R9
    '{4'd10, 6'h00, 1'b1, 5'd1,  32'h0000_0000, 32'h4000_0001, 32'h8000_0002, 1'b0}, // R10
    '{4'd7,  6'h03, 1'b0, 5'd0,  32'h0000_001F, 32'h8000_0000, 32'h8000_0000, 1'b0}  // R7 imm form
  };

  logic        clk;
  logic        rst_n;
  logic [5:0]  fn_code;
  logic        rot_sel;
  logic [4:0]  imm_amt;
  logic [31:0] amt_reg;
  logic [31:0] data_in;
  logic [31:0] result;
  logic        bad_fn;

  int n_checks;
  int n_fail;
  bit done;

  shf_unit uut (
    .fn_code (fn_code),
    .rot_sel (rot_sel),
    .imm_amt (imm_amt),
    .amt_reg (amt_reg),
    .data_in (data_in),
    .result  (result),
    .bad_fn  (bad_fn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // independent bit-level model of the requirements
  function automatic logic [32:0] model(input logic [5:0] fn, input logic sel,
                                        input logic [4:0] imm, input logic [31:0] rs,
                                        input logic [31:0] d);
    logic [31:0] r;
    int n;
    r = '0;
    case (fn)
      6'h00, 6'h02, 6'h03: n = int'(imm);
      6'h04, 6'h06, 6'h07: n = int'(rs % 32);
      default: return {1'b1, 32'h0};
    endcase
    for (int i = 0; i < 32; i++) begin
      case (fn)
        6'h00, 6'h04: r[i] = (i >= n) ? d[i-n] : 1'b0;
        6'h03, 6'h07: r[i] = (i + n < 32) ? d[i+n] : d[31];
        default:      r[i] = sel ? d[(i+n)%32] : ((i + n < 32) ? d[i+n] : 1'b0);
      endcase
    end
    return {1'b0, r};
  endfunction

  task automatic apply(input logic [5:0] fn, input logic sel, input logic [4:0] imm,
                       input logic [31:0] rs, input logic [31:0] d);
    @(posedge clk);
    fn_code = fn; rot_sel = sel; imm_amt = imm; amt_reg = rs; data_in = d;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [31:0] er, input logic eb);
    n_checks++;
    if (result !== er || bad_fn !== eb) begin
      n_fail++;
      $display("FAIL R%0d fn=%h sel=%0d: got result=%h bad=%0d, expected result=%h bad=%0d",
               req, fn_code, rot_sel, result, bad_fn, er, eb);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    logic [32:0] m;
    logic [5:0]  codes [8];
    logic        sels  [8];
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    fn_code = '0; rot_sel = 1'b0; imm_amt = '0; amt_reg = '0; data_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 32'h0, 1'b0); // R1: all-zero inputs give zero result, legal

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].fn, VECS[v].sel, VECS[v].imm, VECS[v].rs, VECS[v].d);
      check(int'(VECS[v].req), VECS[v].exp_res, VECS[v].exp_bad);
    end

    // R1 R2 R3 R4 R5 R6 R8: every legal op at every distance, random operands
    codes = '{6'h00, 6'h02, 6'h02, 6'h03, 6'h04, 6'h06, 6'h06, 6'h07};
    sels  = '{1'b0,  1'b0,  1'b1,  1'b0,  1'b0,  1'b0,  1'b1,  1'b0};
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 32; a++) begin
        logic [31:0] d;
        logic [31:0] rs;
        logic [4:0]  im;
        d  = $urandom();
        rs = ($urandom() & 32'hFFFF_FFE0) | 32'(a);
        im = codes[c][2] ? 5'($urandom()) : 5'(a);
        apply(codes[c], sels[c], im, rs, d);
        m = model(codes[c], sels[c], im, rs, d);
        check(codes[c][2] ? 7 : (c == 2 ? 8 : 2), m[31:0], m[32]);
      end
    end

    // R9 R10: all codes, both selector values
    for (int f = 0; f < 64; f++) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] d;
        logic [31:0] rs;
        logic [4:0]  im;
        d = $urandom(); rs = $urandom(); im = 5'($urandom());
        apply(6'(f), s[0], im, rs, d);
        m = model(6'(f), s[0], im, rs, d);
        check(m[32] ? 9 : 10, m[31:0], m[32]);
      end
    end

    // R8: variable rotate by zero with upper register bits set
    apply(6'h06, 1'b1, 5'd17, 32'hFFFF_FFE0, 32'h0F1E_2D3C);
    check(8, 32'h0F1E_2D3C, 1'b0);
    // R3: full 31-bit fill
    apply(6'h03, 1'b0, 5'd31, 32'h0, 32'h8000_0000);
    check(3, 32'hFFFF_FFFF, 1'b0);
    // R9: code 0x05 is illegal
    apply(6'h05, 1'b1, 5'd1, 32'h1, 32'h1234_5678);
    check(9, 32'h0, 1'b1);

    done = 1'b1;
    summary();
  end

endmodule